// File: doc/BRIEF.md
# Serial Link Lane Code-Group Synchronizer

This block sits behind the 10b/8b decoders of a multi-lane serial receiver and brings each lane into code-group synchronization. Every lane delivers one decoded character per cycle together with a control-character flag and a code/disparity error flag. A per-lane state machine looks for a run of K28.5 comma characters, and the block holds its active-low synchronization request toward the transmitter until every enabled lane has locked. A locked lane that later sees a broken character can fall back to searching, which pulls the request low again and forces the transmitter to restart the link.

Alongside the lock logic, each lane keeps five sticky flags that record which control characters (K28.0, K28.3, K28.4, K28.5, K28.7) have arrived since the lane's flags were last cleared. Per lane, software can enable the lane, pick automatic or manual locking, choose whether a locked lane keeps watching for errors, request a soft relock, and clear the flags.

Characters are a stream. Each lane's character is taken on a clock edge where its valid bit is high. There is no ready signal: the block never applies back-pressure and accepts a valid character on every cycle, so a sender may present a new character each cycle. Cycles with valid low carry no character. The lane controls and the request output are plain level signals.

Top module: `lane_codesync`

## Requirements
- R1: After reset every lane state reads 00, all flag bits read 0 and `sync_req_n` is low.
- R2: Lane state is a 2-bit field at `lane_state[2i+1:2i]`. It reads 00 while searching, 01 while counting K28.5, and 10 once locked. 11 never appears. In automatic mode, a valid error-free K28.5 (`is_k`=1, byte 0xBC) moves a searching lane to 01. The fourth consecutive such character moves it to 10. Each change is visible one cycle after the character.
- R3: In automatic mode, a valid character that carries an error, or that is not an error-free K28.5, returns a counting lane to 00 with its count cleared. A cycle with valid low has no effect on the count.
- R4: `sync_req_n` is low while any enabled lane is not at 10. It goes high one cycle after the last enabled lane reaches 10. A disabled lane is held at 00 and does not hold the request low.
- R5: A locked lane with its resync bit set returns to 00 on a valid errored character, and `sync_req_n` then falls one cycle later. With its resync bit clear, a locked lane stays at 10 through errored characters.
- R6: In manual mode the lane state follows the lane's force bit: 10 one cycle after it is high, 00 one cycle after it is low. Received characters do not change the state.
- R7: A relock pulse returns an enabled lane to 00 on the next cycle, whatever its state and mode.
- R8: Flags of lane i sit at `kseen[5i+4:5i]`: bit 0 = K28.0 (0x1C), bit 1 = K28.3 (0x7C), bit 2 = K28.4 (0x9C), bit 3 = K28.5 (0xBC), bit 4 = K28.7 (0xFC). A flag sets one cycle after a valid, error-free, control character with that byte arrives on an enabled lane, and it stays set. A data character with the same byte, or an errored one, sets nothing.
- R9: A lane's flag-clear bit zeroes only that lane's flags, one cycle later. Clear wins over a set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_valid | input | NLANES | Per-lane character valid |
| ch_byte | input | 8*NLANES | Per-lane decoded byte, lane i at [8i+7:8i] |
| ch_is_k | input | NLANES | Per-lane control-character flag |
| ch_err | input | NLANES | Per-lane code or disparity error |
| lane_en | input | NLANES | Lane enable |
| lane_manual | input | NLANES | 1 = manual lock mode |
| lane_force | input | NLANES | Manual-mode lock level |
| lane_resync | input | NLANES | 1 = locked lane drops on errors |
| lane_relock | input | NLANES | Soft relock pulse |
| kseen_clr | input | NLANES | Per-lane flag clear |
| sync_req_n | output | 1 | Active-low synchronization request |
| lane_state | output | 2*NLANES | Per-lane state code |
| kseen | output | 5*NLANES | Per-lane sticky control-character flags |

## Verification
Lane states and flags are due on the edge that takes the character or control. The request output is due one edge after the lane states that produce it. The bench drives every input one nanosecond after a rising edge and reads results one nanosecond after the next edge. A check of the request therefore waits one extra idle cycle beyond the lane-state check. The bench sweeps K28.5 run lengths 0 to 5 on all lanes and every flag code on every lane, and it computes each expected code and bit position arithmetically.

// File: rtl/lane_codesync_pkg.sv
package lane_codesync_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'b00,
    ST_COUNT  = 2'b01,
    ST_LOCKED = 2'b10
  } lane_st_e;

  localparam int NKFLAGS = 5;
  localparam logic [7:0] KB_28_0 = 8'h1C;
  localparam logic [7:0] KB_28_3 = 8'h7C;
  localparam logic [7:0] KB_28_4 = 8'h9C;
  localparam logic [7:0] KB_28_5 = 8'hBC;
  localparam logic [7:0] KB_28_7 = 8'hFC;

  function automatic logic [NKFLAGS-1:0] kdecode(input logic [7:0] b);
    logic [NKFLAGS-1:0] r;
    r[0] = (b == KB_28_0);
    r[1] = (b == KB_28_3);
    r[2] = (b == KB_28_4);
    r[3] = (b == KB_28_5);
    r[4] = (b == KB_28_7);
    return r;
  endfunction
endpackage

// File: rtl/lane_lock_fsm.sv
module lane_lock_fsm
  import lane_codesync_pkg::*;
#(
  parameter int RUN_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       manual,
  input  logic       force_lock,
  input  logic       resync,
  input  logic       relock,
  input  logic       vld,
  input  logic [7:0] byte_in,
  input  logic       is_k,
  input  logic       err,
  output lane_st_e   st
);
  localparam int CW = (RUN_LEN < 2) ? 1 : $clog2(RUN_LEN + 1);

  logic [CW-1:0] run_q;
  logic          comma;
  assign comma = vld && is_k && !err && (byte_in == KB_28_5);

  always_ff @(posedge clk) begin
    if (!rst_n || !en || relock) begin
      st    <= ST_SEARCH;
      run_q <= '0;
    end else if (manual) begin
      st    <= force_lock ? ST_LOCKED : ST_SEARCH;
      run_q <= '0;
    end else if (vld) begin
      unique case (st)
        ST_SEARCH: begin
          if (comma) begin
            st    <= (RUN_LEN == 1) ? ST_LOCKED : ST_COUNT;
            run_q <= CW'(1);
          end
        end
        ST_COUNT: begin
          if (!comma) begin
            st    <= ST_SEARCH;
            run_q <= '0;
          end else if (run_q == CW'(RUN_LEN - 1)) begin
            st    <= ST_LOCKED;
            run_q <= '0;
          end else begin
            run_q <= run_q + 1'b1;
          end
        end
        ST_LOCKED: begin
          if (resync && err) st <= ST_SEARCH;
        end
        default: st <= ST_SEARCH;
      endcase
    end
  end

  assert_state_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st != 2'b11);

  assert_lock_after_comma_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOCKED && $past(st) == ST_COUNT) |-> $past(comma));

  assert_break_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$past(manual) && !$past(relock) && $past(st) == ST_COUNT
     && $past(vld) && $past(err)) |-> st == ST_SEARCH);

  assert_relock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(relock) |-> st == ST_SEARCH);
endmodule

// File: rtl/lane_kseen.sv
module lane_kseen
  import lane_codesync_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               clr,
  input  logic               vld,
  input  logic [7:0]         byte_in,
  input  logic               is_k,
  input  logic               err,
  output logic [NKFLAGS-1:0] flags
);
  logic [NKFLAGS-1:0] hit;
  assign hit = (en && vld && is_k && !err) ? kdecode(byte_in) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) flags <= '0;
    else               flags <= flags | hit;
  end

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> flags == '0);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> (flags & $past(flags)) == $past(flags));

  assert_one_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: rtl/link_sync_req.sv
module link_sync_req #(
  parameter int NLANES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLANES-1:0] lane_en,
  input  logic [NLANES-1:0] lane_locked,
  output logic              sync_req_n
);
  logic all_ok;
  assign all_ok = &(lane_locked | ~lane_en);

  always_ff @(posedge clk) begin
    if (!rst_n) sync_req_n <= 1'b0;
    else        sync_req_n <= all_ok;
  end
endmodule

// File: rtl/lane_codesync.sv
module lane_codesync
  import lane_codesync_pkg::*;
#(
  parameter int NLANES  = 4,
  parameter int RUN_LEN = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NLANES-1:0]      ch_valid,
  input  logic [8*NLANES-1:0]    ch_byte,
  input  logic [NLANES-1:0]      ch_is_k,
  input  logic [NLANES-1:0]      ch_err,
  input  logic [NLANES-1:0]      lane_en,
  input  logic [NLANES-1:0]      lane_manual,
  input  logic [NLANES-1:0]      lane_force,
  input  logic [NLANES-1:0]      lane_resync,
  input  logic [NLANES-1:0]      lane_relock,
  input  logic [NLANES-1:0]      kseen_clr,
  output logic                   sync_req_n,
  output logic [2*NLANES-1:0]    lane_state,
  output logic [NKFLAGS*NLANES-1:0] kseen
);
  logic [NLANES-1:0] locked;

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    lane_st_e st;

    lane_lock_fsm #(.RUN_LEN(RUN_LEN)) i_fsm (
      .clk(clk), .rst_n(rst_n), .en(lane_en[i]), .manual(lane_manual[i]),
      .force_lock(lane_force[i]), .resync(lane_resync[i]),
      .relock(lane_relock[i]), .vld(ch_valid[i]), .byte_in(ch_byte[8*i +: 8]),
      .is_k(ch_is_k[i]), .err(ch_err[i]), .st(st)
    );

    lane_kseen i_kseen (
      .clk(clk), .rst_n(rst_n), .en(lane_en[i]), .clr(kseen_clr[i]),
      .vld(ch_valid[i]), .byte_in(ch_byte[8*i +: 8]), .is_k(ch_is_k[i]),
      .err(ch_err[i]), .flags(kseen[NKFLAGS*i +: NKFLAGS])
    );

    assign lane_state[2*i +: 2] = st;
    assign locked[i]            = (st == ST_LOCKED);
  end

  link_sync_req #(.NLANES(NLANES)) i_req (
    .clk(clk), .rst_n(rst_n), .lane_en(lane_en), .lane_locked(locked),
    .sync_req_n(sync_req_n)
  );

  assert_release_needs_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req_n |-> $past((locked | ~lane_en) == {NLANES{1'b1}}));

  assert_disabled_searching_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!lane_en[0]) |-> lane_state[1:0] == 2'b00);
endmodule

// File: tb/test_lane_codesync.sv
module test_lane_codesync;
  localparam int NL = 4;
  localparam logic [7:0] KCODE [5] = '{8'h1C, 8'h7C, 8'h9C, 8'hBC, 8'hFC};

  logic clk = 1'b0;
  logic rst_n;
  logic [NL-1:0] ch_valid, ch_is_k, ch_err;
  logic [8*NL-1:0] ch_byte;
  logic [NL-1:0] lane_en, lane_manual, lane_force, lane_resync, lane_relock, kseen_clr;
  logic sync_req_n;
  logic [2*NL-1:0] lane_state;
  logic [5*NL-1:0] kseen;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lane_codesync #(.NLANES(NL), .RUN_LEN(4)) i_lane_codesync (
    .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_byte(ch_byte),
    .ch_is_k(ch_is_k), .ch_err(ch_err), .lane_en(lane_en),
    .lane_manual(lane_manual), .lane_force(lane_force),
    .lane_resync(lane_resync), .lane_relock(lane_relock),
    .kseen_clr(kseen_clr), .sync_req_n(sync_req_n),
    .lane_state(lane_state), .kseen(kseen)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [NL-1:0] v, input logic [7:0] b,
                      input logic k, input logic e);
    ch_valid = v; ch_byte = {NL{b}}; ch_is_k = {NL{k}}; ch_err = {NL{e}};
    @(posedge clk); #1;
    ch_valid = '0; ch_err = '0;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  task automatic relock(input logic [NL-1:0] m);
    lane_relock = m; idle(); lane_relock = '0;
  endtask

  task automatic lock_all();
    relock('1);
    for (int j = 0; j < 4; j++) step('1, 8'hBC, 1'b1, 1'b0);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ch_valid = '0; ch_byte = '0; ch_is_k = '0; ch_err = '0;
    lane_en = '1; lane_manual = '0; lane_force = '0; lane_resync = '0;
    lane_relock = '0; kseen_clr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk("R1 state", lane_state, 0);
    chk("R1 flags", kseen, 0);
    chk("R1 sync_req_n", sync_req_n, 0);

    // R2/R3 sweep of K28.5 run lengths followed by a data character
    for (int n = 0; n <= 5; n++) begin
      relock('1);
      for (int j = 0; j < n; j++) step('1, 8'hBC, 1'b1, 1'b0);
      chk("R2 run state", lane_state, {NL{(n == 0) ? 2'b00 : (n < 4) ? 2'b01 : 2'b10}});
      step('1, 8'h4A, 1'b0, 1'b0);
      chk("R3 after break", lane_state, {NL{(n >= 4) ? 2'b10 : 2'b00}});
      idle();
      chk("R4 request after run", sync_req_n, (n >= 4) ? 1 : 0);
    end

    // R3 errored comma while counting
    relock('1);
    step('1, 8'hBC, 1'b1, 1'b0); step('1, 8'hBC, 1'b1, 1'b0);
    step('1, 8'hBC, 1'b1, 1'b1);
    chk("R3 error clears count", lane_state, 0);

    // R3 idle cycles do not break a run
    relock('1);
    step('1, 8'hBC, 1'b1, 1'b0); step('1, 8'hBC, 1'b1, 1'b0);
    step('0, 8'h00, 1'b0, 1'b1);
    step('1, 8'hBC, 1'b1, 1'b0);
    chk("R3 gap keeps count", lane_state, {NL{2'b01}});
    step('1, 8'hBC, 1'b1, 1'b0);
    chk("R3 gap then lock", lane_state, {NL{2'b10}});

    // R4 lane 3 short of lock holds the request; disabling it releases
    relock('1);
    for (int j = 0; j < 3; j++) step('1, 8'hBC, 1'b1, 1'b0);
    step(4'b0111, 8'hBC, 1'b1, 1'b0);
    idle();
    chk("R4 one lane short", sync_req_n, 0);
    lane_en = 4'b0111; idle();
    chk("R4 disabled lane state", lane_state[7:6], 0);
    chk("R4 disabled lane released", sync_req_n, 1);
    lane_en = '1;
    idle();
    chk("R4 re-enabled lane", sync_req_n, 0);

    // R5 loss of lock with and without resync
    lock_all();
    chk("R5 all locked", sync_req_n, 1);
    lane_resync = 4'b0001;
    step(4'b0011, 8'h00, 1'b0, 1'b1);
    chk("R5 resync lane drops", lane_state[1:0], 0);
    chk("R5 no-resync lane holds", lane_state[3:2], 2'b10);
    chk("R5 request still high", sync_req_n, 1);
    idle();
    chk("R5 request falls", sync_req_n, 0);
    lane_resync = '0;

    // R6 manual lock
    lane_manual = 4'b0100; lane_force = 4'b0100; idle();
    chk("R6 forced lock", lane_state[5:4], 2'b10);
    step('1, 8'h00, 1'b0, 1'b1);
    chk("R6 chars ignored", lane_state[5:4], 2'b10);
    lane_force = '0; step('1, 8'hBC, 1'b1, 1'b0);
    chk("R6 force low", lane_state[5:4], 0);
    lane_manual = '0;

    // R7 relock from locked
    lock_all();
    relock(4'b1000);
    chk("R7 relock lane 3", lane_state, {2'b00, 2'b10, 2'b10, 2'b10});

    // R8 every flag code on every lane
    for (int l = 0; l < NL; l++) begin
      for (int c = 0; c < 5; c++) begin
        kseen_clr = '1; idle(); kseen_clr = '0;
        step(NL'(1) << l, KCODE[c], 1'b1, 1'b0);
        chk("R8 flag position", kseen, 32'(1) << (5*l + c));
      end
    end
    kseen_clr = '1; idle(); kseen_clr = '0;
    step('1, 8'hFC, 1'b0, 1'b0);
    chk("R8 data byte sets nothing", kseen, 0);
    step('1, 8'h1C, 1'b1, 1'b1);
    chk("R8 errored sets nothing", kseen, 0);
    step('1, 8'h7C, 1'b1, 1'b0); step('1, 8'h9C, 1'b1, 1'b0);
    chk("R8 sticky", kseen, {NL{5'b00110}});

    // R9 per-lane clear and clear priority
    kseen_clr = 4'b0001;
    step(4'b0001, 8'hFC, 1'b1, 1'b0);
    kseen_clr = '0;
    chk("R9 clear wins, others kept", kseen, {{(NL-1){5'b00110}}, 5'b00000});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule